// File: doc/BRIEF.md
# Combined Legacy-Line and Message Interrupt Aggregator

This block gathers four legacy level-sensitive interrupt lines from a PCIe root port and a single "message interrupt pending" summary from a separate message-capture block. It records them in one status register, filters them through one enable register, and drives a single level interrupt toward the host processor. Software reaches both registers through a plain register port with an address, a write strobe, write data and combinational read data.

Status bits clear when software writes a one to them. A status bit whose source is still asserted cannot be cleared, because a new set event always beats a clear in the same cycle. An interrupt handler must therefore read, acknowledge and read again until the line field comes back empty. Software masks a single line by rewriting the enable register with that bit changed, and at start-up it normally enables all four line bits and the message bit in one write. The asynchronous inputs pass through a synchronizer of `SYNC_STAGES` flops before they reach the status register.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted and right after it, the status register and the enable register read zero and `irq_o` is low.
- R2: Register map. Address 0 is status and address 1 is enable. The legacy line field sits at bits [8:5], with line n at bit 5+n. The message summary bit is bit 3. Every other bit reads zero in both registers and ignores writes.
- R3: A legacy line held high sets its status bit within `SYNC_STAGES`+1 clock edges. The bit stays set after the line drops, until software clears it.
- R4: Writing to address 0 clears each status bit written with a one and leaves each bit written with a zero unchanged.
- R5: When a set event and a clear hit the same status bit in the same cycle, the bit stays set. A bit whose source stays asserted survives any clear.
- R6: A write to address 1 loads the enable register with the implemented bits of the write data, and the value reads back unchanged.
- R7: `irq_o` is high exactly when some bit is set in both the status and enable registers. It follows register changes with no further delay.
- R8: The message summary input sets status bit 3 in the same way, with the same capture and clear rules as the legacy lines.
- R9: A write to the enable register does not change status, and a status write does not change enable. Writes to addresses 2 and 3 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_line | input | 4 | Legacy interrupt lines, level, asynchronous |
| msi_pend | input | 1 | Message interrupt pending summary, level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 status, 1 enable) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined level interrupt to the processor |

## Verification
The assertions take three things for granted. The synchronized source vector is the only way status bits get set. The write strobe is a clean single-cycle pulse with a stable address. The source lines change slowly compared with the clock, so a new level has gone through the synchronizer before anyone depends on it. The stimulus keeps to this: it changes the lines and the message summary only on falling edges, then holds them for four cycles before it checks anything. Each write lasts exactly one cycle. Random rounds mix line patterns, acknowledge masks, enable values and writes to unused addresses while the sources are held steady.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Next value of one status bit: a set event beats a clear in the same cycle.
  function automatic logic w1c_bit(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  // One bit of the enabled-pending vector.
  function automatic logic pend_bit(input logic stat, input logic en);
    return stat & en;
  endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] stat_q
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[b] <= 1'b0;
      else        stat_q[b] <= irq_agg_pkg::w1c_bit(stat_q[b], clr_vec[b], set_vec[b]);
    end
  end
endmodule

// File: rtl/irq_agg_enable.sv
module irq_agg_enable #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] impl_mask,
  output logic [REG_W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata & impl_mask;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int REG_W       = 16,
  parameter int INTX_LSB    = 5,
  parameter int MSI_BIT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        intx_line,
  input  logic              msi_pend,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  localparam int NLINES = 4;
  localparam int NSRC   = NLINES + 1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);

  logic [NSRC-1:0]  src_s;
  logic [REG_W-1:0] impl_mask;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] pending;
  logic             stat_wr;
  logic             en_wr;

  irq_agg_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({msi_pend, intx_line}), .q(src_s)
  );

  // Place each synchronized source at its bit of the status word.
  for (genvar b = 0; b < REG_W; b++) begin : g_map
    if (b >= INTX_LSB && b < INTX_LSB + NLINES) begin : g_line
      assign set_vec[b]   = src_s[b-INTX_LSB];
      assign impl_mask[b] = 1'b1;
    end else if (b == MSI_BIT) begin : g_msg
      assign set_vec[b]   = src_s[NLINES];
      assign impl_mask[b] = 1'b1;
    end else begin : g_none
      assign set_vec[b]   = 1'b0;
      assign impl_mask[b] = 1'b0;
    end
  end

  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
  assign en_wr   = reg_wr && (reg_addr == ADDR_EN);
  assign clr_vec = stat_wr ? (reg_wdata & impl_mask) : '0;

  irq_agg_status #(.REG_W(REG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .stat_q(stat_q)
  );

  irq_agg_enable #(.REG_W(REG_W)) u_enable (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .wdata(reg_wdata),
    .impl_mask(impl_mask), .en_q(en_q)
  );

  for (genvar b = 0; b < REG_W; b++) begin : g_pend
    assign pending[b] = irq_agg_pkg::pend_bit(stat_q[b], en_q[b]);
  end

  assign irq_o = |pending;

  always_comb begin
    unique case (reg_addr)
      ADDR_STAT: reg_rdata = stat_q;
      ADDR_EN:   reg_rdata = en_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] en_q,
  input logic [REG_W-1:0] set_vec,
  input logic [REG_W-1:0] clr_vec,
  input logic [REG_W-1:0] impl_mask,
  input logic             en_wr,
  input logic             irq_o
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && en_q == '0));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | en_q) & ~impl_mask) == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0 && set_vec == '0) |=> $stable(stat_q));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));

  p_masked_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 || stat_q == '0) |-> !irq_o);
endmodule

bind irq_aggregator irq_aggregator_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .en_q(en_q), .set_vec(set_vec),
  .clr_vec(clr_vec), .impl_mask(impl_mask), .en_wr(en_wr), .irq_o(irq_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IMPL = 16'h01E8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_line = '0;
  logic        msi_pend = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_stat = '0;
  logic [15:0] m_en = '0;
  logic [3:0]  cur_ix = '0;
  logic        cur_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .intx_line(intx_line), .msi_pend(msi_pend),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Status word from source levels: lines at [8:5], message summary at bit 3.
  function automatic logic [15:0] src_word(input logic [3:0] ix, input logic m);
    return {7'b0, ix, 1'b0, m, 3'b0};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic lines(input logic [3:0] ix, input logic m);
    @(negedge clk);
    intx_line = ix; msi_pend = m; cur_ix = ix; cur_m = m;
    repeat (4) @(negedge clk);
    m_stat = m_stat | src_word(ix, m);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_stat = (m_stat & ~(d & IMPL)) | src_word(cur_ix, cur_m);
    else if (a == 2'd1) m_en = d & IMPL;
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    rd(2'd0, v); chk({req, " status"}, v, m_stat);
    rd(2'd1, v); chk({req, " enable"}, v, m_en);
    chk({req, " irq"}, {15'b0, irq_o}, {15'b0, |(m_stat & m_en)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R2 enable implemented bits", v, 16'h01E8);
    wr(2'd1, 16'h01E8);
    check_all("R6 enable readback");

    lines(4'b0101, 1'b0);
    rd(2'd0, v); chk("R3 lines set status", v, 16'h00A0);
    chk("R7 irq high", {15'b0, irq_o}, 16'h0001);
    lines(4'b0000, 1'b0);
    rd(2'd0, v); chk("R3 status held after drop", v, 16'h00A0);

    wr(2'd0, 16'h0020);
    rd(2'd0, v); chk("R4 w1c single bit", v, 16'h0080);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R4 zero write no change", v, 16'h0080);

    lines(4'b0000, 1'b1);
    rd(2'd0, v); chk("R8 message bit set", v, 16'h0088);
    wr(2'd0, 16'h0008);
    rd(2'd0, v); chk("R5 set wins while asserted", v, 16'h0088);
    lines(4'b0000, 1'b0);
    wr(2'd0, 16'h0008);
    rd(2'd0, v); chk("R8 message bit cleared", v, 16'h0080);

    wr(2'd1, 16'h0000);
    chk("R7 masked irq low", {15'b0, irq_o}, 16'h0000);
    rd(2'd0, v); chk("R9 enable write keeps status", v, 16'h0080);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
    check_all("R9 unused address writes");
    wr(2'd1, 16'h0100);
    chk("R7 single enabled mismatch low", {15'b0, irq_o}, 16'h0000);
    wr(2'd0, 16'hFFFF);
    rd(2'd1, v); chk("R9 status write keeps enable", v, 16'h0100);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: lines(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
        1: wr(2'd0, 16'($urandom));
        2: wr(2'd1, 16'($urandom));
        default: wr(2'($urandom_range(2, 3)), 16'($urandom));
      endcase
      check_all("R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule